// File: doc/BRIEF.md
# Dual-Port Semaphore Bank

This block holds a small bank of hardware semaphores that two independent ports, called left and right, use to share resources. It has no storage array. Each port presents a select, a write/read flag, an address and a write data bus. A port asks for a semaphore by writing 0 to it and gives it back by writing 1. A read tells the port whether it currently holds that semaphore.

Each semaphore records a request bit for each port. While one port holds a semaphore, a request from the other port is kept, and ownership moves to the waiting port on the clock edge at which the holder releases. Read results are loaded into a per-port output register and stay there until that port reads again. Semaphore accesses are ignored while the port's memory enable is active. Reset does not clear the semaphores: software frees them at start-up by writing 1 from both ports.

Top module: `sem_bank`

## Requirements
- R1: The semaphore index is taken from address bits [2:0], which gives eight semaphores. Address bits above bit 2 have no effect on a semaphore access.
- R2: In an accepted write, bit 0 of the write data selects the action: 0 records a request from that port and 1 clears that port's request, which releases the semaphore or cancels a pending request. The other data bits have no effect.
- R3: An accepted read returns all zeros when the reading port holds the indexed semaphore and all ones otherwise. While one port holds a semaphore, the other port reads all ones.
- R4: At most one port holds a semaphore at any time. A semaphore held by one port keeps its owner until that owner writes to it. When the owner releases it and no request is pending, both ports read all ones.
- R5: If the non-owning port has a request recorded when the owner releases, the requester holds the semaphore from the next clock edge. A request and a release in the same cycle also hand the semaphore over.
- R6: Every bit of a port's read data carries the same value. The output register is loaded on the clock edge that accepts the read. It reflects the semaphore state before any write the opposite port makes in the same cycle.
- R7: A port's read data keeps its value until that port's next accepted read, whatever the other port does in the meantime.
- R8: A port's access is accepted only when its select is 1 and its memory enable is 0. Otherwise the access has no effect on any semaphore or on the read data.
- R9: When both ports write a request to the same free semaphore in the same cycle, the left port gets it.
- R10: Synchronous reset (rst=1) sets both read data outputs to all ones. The semaphore states are not changed by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable; blocks semaphore access when 1 |
| l_wr | input | 1 | Left access type: 1 write, 0 read |
| l_addr | input | ADDR_W (13) | Left address; bits [2:0] index the semaphore |
| l_wdata | input | DATA_W (8) | Left write data; bit 0 used |
| l_rdata | output | DATA_W (8) | Left registered read data |
| r_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable; blocks semaphore access when 1 |
| r_wr | input | 1 | Right access type: 1 write, 0 read |
| r_addr | input | ADDR_W (13) | Right address; bits [2:0] index the semaphore |
| r_wdata | input | DATA_W (8) | Right write data; bit 0 used |
| r_rdata | output | DATA_W (8) | Right registered read data |

## Verification
The assertions assume that the inputs are stable around each rising edge. They also assume that, apart from the reset-only checks, the semaphores start in a known state. Before any check that depends on the semaphore state, the stimulus frees all eight semaphores by writing 1 from both ports. Random traffic then selects the port, the memory enable, the direction, the full address and the data independently. Collisions on the same semaphore in the same cycle come up often, so ties, handovers and simultaneous read-and-write cases are covered both by chance and by directed steps.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int unsigned SEM_N  = 8;
    localparam int unsigned SEM_AW = $clog2(SEM_N);

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_READ = 2'd1,
        OP_TAKE = 2'd2,
        OP_DROP = 2'd3
    } sem_op_e;

    typedef struct packed {
        sem_op_e            op;
        logic [SEM_AW-1:0]  idx;
    } sem_acc_t;

    function automatic sem_op_e classify(input logic sel, input logic mem_en,
                                         input logic wr, input logic bit0);
        if (!sel || mem_en) return OP_IDLE;
        if (!wr)            return OP_READ;
        return bit0 ? OP_DROP : OP_TAKE;
    endfunction

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec
    import sem_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              sel,
    input  logic              mem_en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bit0,
    output sem_acc_t          acc,
    output logic [SEM_N-1:0]  take_vec,
    output logic [SEM_N-1:0]  drop_vec
);
    always_comb begin
        acc.op  = classify(sel, mem_en, wr, bit0);
        acc.idx = addr[SEM_AW-1:0];
    end

    for (genvar g = 0; g < SEM_N; g++) begin : g_dec
        assign take_vec[g] = (acc.op == OP_TAKE) && (acc.idx == SEM_AW'(g));
        assign drop_vec[g] = (acc.op == OP_DROP) && (acc.idx == SEM_AW'(g));
    end
endmodule

// File: rtl/sem_latch.sv
module sem_latch (
    input  logic clk,
    input  logic take_l,
    input  logic drop_l,
    input  logic take_r,
    input  logic drop_r,
    output logic own_l,
    output logic own_r
);
    // Request bits are deliberately not reset; software frees the latch.
    logic req_l, req_r, tok_r;
    logic nreq_l, nreq_r, ntok_r;

    assign own_l = req_l && (!req_r || !tok_r);
    assign own_r = req_r && (!req_l ||  tok_r);

    always_comb begin
        nreq_l = take_l ? 1'b1 : (drop_l ? 1'b0 : req_l);
        nreq_r = take_r ? 1'b1 : (drop_r ? 1'b0 : req_r);
        if (nreq_l && nreq_r)
            ntok_r = own_r;          // holder keeps it; free tie goes left
        else
            ntok_r = nreq_r;
    end

    always_ff @(posedge clk) begin
        req_l <= nreq_l;
        req_r <= nreq_r;
        tok_r <= ntok_r;
    end
endmodule

// File: rtl/sem_rd_reg.sv
module sem_rd_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              not_owned,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '1;
        else if (load)
            rdata <= {DATA_W{not_owned}};
    end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic              l_mem_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_mem_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    sem_acc_t          acc_l, acc_r;
    logic [SEM_N-1:0]  take_l, drop_l, take_r, drop_r;
    logic [SEM_N-1:0]  own_l, own_r;

    sem_port_dec #(.ADDR_W(ADDR_W)) u_dec_l (
        .sel(l_sel), .mem_en(l_mem_en), .wr(l_wr), .addr(l_addr),
        .bit0(l_wdata[0]), .acc(acc_l), .take_vec(take_l), .drop_vec(drop_l)
    );

    sem_port_dec #(.ADDR_W(ADDR_W)) u_dec_r (
        .sel(r_sel), .mem_en(r_mem_en), .wr(r_wr), .addr(r_addr),
        .bit0(r_wdata[0]), .acc(acc_r), .take_vec(take_r), .drop_vec(drop_r)
    );

    for (genvar g = 0; g < SEM_N; g++) begin : g_sem
        sem_latch u_latch (
            .clk(clk),
            .take_l(take_l[g]), .drop_l(drop_l[g]),
            .take_r(take_r[g]), .drop_r(drop_r[g]),
            .own_l(own_l[g]),   .own_r(own_r[g])
        );
    end

    sem_rd_reg #(.DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst(rst), .load(acc_l.op == OP_READ),
        .not_owned(!own_l[acc_l.idx]), .rdata(l_rdata)
    );

    sem_rd_reg #(.DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst(rst), .load(acc_r.op == OP_READ),
        .not_owned(!own_r[acc_r.idx]), .rdata(r_rdata)
    );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              l_sel,
    input logic              l_mem_en,
    input logic              l_wr,
    input logic [2:0]        l_idx,
    input logic              l_bit0,
    input logic [DATA_W-1:0] l_rdata,
    input logic              r_sel,
    input logic              r_mem_en,
    input logic              r_wr,
    input logic [2:0]        r_idx,
    input logic              r_bit0,
    input logic [DATA_W-1:0] r_rdata,
    input logic [7:0]        own_l,
    input logic [7:0]        own_r
);
    logic l_acc, r_acc, l_rd, r_rd;
    assign l_acc = l_sel && !l_mem_en;
    assign r_acc = r_sel && !r_mem_en;
    assign l_rd  = l_acc && !l_wr;
    assign r_rd  = r_acc && !r_wr;

    AST_RD_REPLICATE_L: assert property (@(posedge clk) disable iff (rst)
        (l_rdata == '0) || (l_rdata == '1)); // R6
    AST_RD_REPLICATE_R: assert property (@(posedge clk) disable iff (rst)
        (r_rdata == '0) || (r_rdata == '1)); // R6
    AST_RD_HOLD_L: assert property (@(posedge clk) disable iff (rst)
        !l_rd |=> $stable(l_rdata)); // R7
    AST_RD_HOLD_R: assert property (@(posedge clk) disable iff (rst)
        !r_rd |=> $stable(r_rdata)); // R7
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!l_acc && !r_acc) |=> ($stable(own_l) && $stable(own_r))); // R8

    for (genvar g = 0; g < 8; g++) begin : g_chk
        logic lw, rw, lt, rt, ld;
        assign lw = l_acc && l_wr && (l_idx == 3'(g));
        assign rw = r_acc && r_wr && (r_idx == 3'(g));
        assign lt = lw && !l_bit0;
        assign rt = rw && !r_bit0;
        assign ld = lw && l_bit0;

        AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
            !(own_l[g] && own_r[g])); // R4
        AST_OWNER_KEEPS_R: assert property (@(posedge clk) disable iff (rst)
            (own_r[g] && !rw) |=> own_r[g]); // R4
        AST_OWNER_KEEPS_L: assert property (@(posedge clk) disable iff (rst)
            (own_l[g] && !lw) |=> own_l[g]); // R4
        AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
            (own_l[g] && ld && rt) |=> own_r[g]); // R5
        AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
            (!own_l[g] && !own_r[g] && lt && rt) |=> own_l[g]); // R9
    end
endmodule

bind sem_bank sem_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_idx(l_addr[2:0]),
    .l_bit0(l_wdata[0]), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_idx(r_addr[2:0]),
    .r_bit0(r_wdata[0]), .r_rdata(r_rdata),
    .own_l(own_l), .own_r(own_r)
);

// File: tb/tb_sem_bank.sv
module tb_sem_bank;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 13;
    localparam int DATA_W     = 8;
    localparam int NS         = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              l_sel, l_mem_en, l_wr, r_sel, r_mem_en, r_wr;
    logic [ADDR_W-1:0] l_addr, r_addr;
    logic [DATA_W-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    sem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: owner 0 free, 1 left, 2 right; request bits per port.
    int                own_m [NS];
    bit                pl [NS], pr [NS];
    logic [DATA_W-1:0] exp_l, exp_r;
    int                vecs = 0, bad = 0;
    string             tag = "R10";

    task automatic check(input string t, input logic [DATA_W-1:0] got,
                         input logic [DATA_W-1:0] exp);
        vecs++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", t, got, exp, $time);
        end
    endtask

    task automatic model_update();
        bit al, ar;
        int il, ir;
        al = l_sel && !l_mem_en;
        ar = r_sel && !r_mem_en;
        il = int'(l_addr[2:0]);
        ir = int'(r_addr[2:0]);
        if (al && !l_wr) exp_l = (own_m[il] == 1) ? '0 : '1;
        if (ar && !r_wr) exp_r = (own_m[ir] == 2) ? '0 : '1;
        if (al && l_wr) pl[il] = !l_wdata[0];
        if (ar && r_wr) pr[ir] = !r_wdata[0];
        for (int i = 0; i < NS; i++) begin
            if (own_m[i] == 1 && !pl[i])      own_m[i] = pr[i] ? 2 : 0;
            else if (own_m[i] == 2 && !pr[i]) own_m[i] = pl[i] ? 1 : 0;
            else if (own_m[i] == 0)           own_m[i] = pl[i] ? 1 : (pr[i] ? 2 : 0);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check({tag, " left"},  l_rdata, exp_l);
        check({tag, " right"}, r_rdata, exp_r);
    endtask

    task automatic setl(input bit s, input bit m, input bit w,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        l_sel = s; l_mem_en = m; l_wr = w; l_addr = a; l_wdata = d;
    endtask

    task automatic setr(input bit s, input bit m, input bit w,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        r_sel = s; r_mem_en = m; r_wr = w; r_addr = a; r_wdata = d;
    endtask

    task automatic idle();
        setl(0, 0, 0, '0, '0);
        setr(0, 0, 0, '0, '0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NS; i++) begin own_m[i] = 0; pl[i] = 0; pr[i] = 0; end
        exp_l = '1; exp_r = '1;
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset left",  l_rdata, '1);
        check("R10 reset right", r_rdata, '1);

        // Free every semaphore from both ports
        tag = "R10";
        for (int i = 0; i < NS; i++) begin
            setl(1, 0, 1, ADDR_W'(i), 8'h01);
            setr(1, 0, 1, ADDR_W'(i), 8'h01);
            step();
        end

        // R1: upper address bits ignored
        tag = "R1";
        idle(); setl(1, 0, 1, 13'h1ABD, 8'h00); step();
        idle(); setl(1, 0, 0, 13'h0FF5, 8'h00); setr(1, 0, 0, 13'h0005, 8'h00); step();

        // R2: only bit 0 of write data matters
        tag = "R2";
        idle(); setl(1, 0, 1, 13'h0002, 8'hFE); step();
        idle(); setl(1, 0, 0, 13'h0002, 8'h00); step();
        idle(); setl(1, 0, 1, 13'h0002, 8'h01); step();
        idle(); setl(1, 0, 0, 13'h0002, 8'h00); step();

        // R4: non-owner write of 1 leaves owner in place, then release frees
        tag = "R4";
        idle(); setr(1, 0, 1, 13'h0003, 8'h00); step();
        idle(); setl(1, 0, 1, 13'h0003, 8'hFF); step();
        idle(); setr(1, 0, 0, 13'h0003, 8'h00); setl(1, 0, 0, 13'h0003, 8'h00); step();
        idle(); setr(1, 0, 1, 13'h0003, 8'h01); step();
        idle(); setr(1, 0, 0, 13'h0003, 8'h00); setl(1, 0, 0, 13'h0003, 8'h00); step();

        // R5: pending request takes over on release
        tag = "R5";
        idle(); setl(1, 0, 1, 13'h0004, 8'h00); step();
        idle(); setr(1, 0, 1, 13'h0004, 8'h00); step();
        idle(); setr(1, 0, 0, 13'h0004, 8'h00); step();
        idle(); setl(1, 0, 1, 13'h0004, 8'h01); step();
        idle(); setr(1, 0, 0, 13'h0004, 8'h00); setl(1, 0, 0, 13'h0004, 8'h00); step();
        idle(); setr(1, 0, 1, 13'h0004, 8'h01); step();

        // R6: read in the same cycle as an opposite-port request sees old state
        tag = "R6";
        idle(); setl(1, 0, 0, 13'h0000, 8'h00); setr(1, 0, 1, 13'h0000, 8'h00); step();
        idle(); setl(1, 0, 0, 13'h0000, 8'h00); step();
        idle(); setr(1, 0, 1, 13'h0000, 8'h01); step();

        // R7: read data held while the other side changes state
        tag = "R7";
        idle(); setl(1, 0, 1, 13'h0006, 8'h00); step();
        idle(); setl(1, 0, 0, 13'h0006, 8'h00); step();
        idle(); setr(1, 0, 1, 13'h0006, 8'h00); step();
        idle(); setl(1, 0, 1, 13'h0006, 8'h01); step();
        idle(); step();
        idle(); setr(1, 0, 1, 13'h0006, 8'h01); step();

        // R8: blocked accesses have no effect
        tag = "R8";
        idle(); setl(1, 1, 1, 13'h0007, 8'h00); setr(0, 0, 1, 13'h0007, 8'h00); step();
        idle(); setl(1, 1, 0, 13'h0007, 8'h00); step();
        idle(); setl(1, 0, 0, 13'h0007, 8'h00); setr(1, 0, 0, 13'h0007, 8'h00); step();

        // R9: simultaneous request on a free semaphore goes left
        tag = "R9";
        idle(); setl(1, 0, 1, 13'h0001, 8'h00); setr(1, 0, 1, 13'h0001, 8'h00); step();
        idle(); setl(1, 0, 0, 13'h0001, 8'h00); setr(1, 0, 0, 13'h0001, 8'h00); step();
        idle(); setl(1, 0, 1, 13'h0001, 8'h01); step();
        idle(); setl(1, 0, 0, 13'h0001, 8'h00); setr(1, 0, 0, 13'h0001, 8'h00); step();

        // R3: random traffic against the model
        tag = "R3";
        for (int n = 0; n < 4000; n++) begin
            setl(($urandom % 10) < 7, ($urandom % 10) == 0, $urandom % 2,
                 ADDR_W'($urandom), DATA_W'($urandom));
            setr(($urandom % 10) < 7, ($urandom % 10) == 0, $urandom % 2,
                 ADDR_W'($urandom), DATA_W'($urandom));
            step();
        end
        idle();
        step();
        summary();
    end
endmodule